// File: doc/BRIEF.md
# Unaligned Word Merge Unit

This block carries out the byte merging behind the four partial-word memory operations of a 32-bit little-endian machine. Two of them pull part of a word into a register (load-left, load-right) and two put part of a register into a word (store-left, store-right). The caller starts one operation with a byte address, the current register value and a destination register index. The block reads the aligned word that holds the addressed byte, and splices register bytes and memory bytes according to the byte offset. A load returns the merged register value. A store writes the merged word back to the same aligned address.

Memory is reached through a request/valid handshake. The block raises a request and holds it until the memory answers with valid. Loads issue one read. Stores issue one read and then one full-word write. A one-cycle completion pulse marks the end of each operation. The block takes a new operation only while it is idle.

Top module: `unaligned_merge`

## Requirements
- R1: Every memory request carries the operation's address with bits [1:0] forced to zero. Bits [31:2] are the operation's address bits.
- R2: With op = 2'b00 (load-left) and byte offset k = addr[1:0], result byte j equals memory byte j-(3-k) when j >= 3-k. Otherwise it equals register byte j.
- R3: With op = 2'b01 (load-right), result byte j equals memory byte j+k when j <= 3-k. Otherwise it equals register byte j. At k = 0 the result is the whole memory word.
- R4: With op = 2'b10 (store-left), written byte j equals register byte j+3-k when j <= k. Otherwise it equals memory byte j. At k = 3 the whole register is written.
- R5: With op = 2'b11 (store-right), written byte j equals register byte j-k when j >= k. Otherwise it equals memory byte j.
- R6: rf_we is high only in the done cycle of a load whose destination index is nonzero. A store never raises rf_we, and it still writes memory whatever register it came from.
- R7: An operation first reads (mem_we = 0) and holds the request and address until mem_valid. A store then issues exactly one write with mem_be = 4'b1111 and holds it until mem_valid. A load issues no write.
- R8: done is a single-cycle pulse in the cycle after the memory answer that completes the operation. rf_wdata holds the load result during that cycle.
- R9: start is ignored while busy is high. Such a start causes no extra operation and no extra done pulse.
- R10: After reset the block is idle, with busy, mem_req, done and rf_we all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (taken when idle) |
| op | input | 2 | 00 load-left, 01 load-right, 10 store-left, 11 store-right |
| addr | input | 32 | Byte address |
| reg_val | input | 32 | Current register value (load destination or store source) |
| reg_sel | input | 5 | Register index |
| busy | output | 1 | Operation in progress |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Aligned word address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables for writes |
| mem_valid | input | 1 | Memory answer or write acceptance |
| mem_rdata | input | 32 | Aligned word read |
| rf_wdata | output | 32 | Merged load result |
| rf_we | output | 1 | Register write enable |
| done | output | 1 | Completion pulse |

## Verification
The checker assumes that the memory raises mem_valid only while mem_req is high, for exactly one cycle per request, and that mem_rdata is stable in that cycle. The bench memory model answers only requests it sees pending, after a programmable latency, and drops valid in the next cycle. That latency is varied, and it is stretched for the operation during which a stray start is injected. Every operation is otherwise launched only after busy has fallen.

// File: rtl/unaligned_merge.sv
module unaligned_merge #(
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    op,
  input  logic [31:0]   addr,
  input  logic [31:0]   reg_val,
  input  logic [RW-1:0] reg_sel,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [31:0]   mem_addr,
  output logic [31:0]   mem_wdata,
  output logic [3:0]    mem_be,
  input  logic          mem_valid,
  input  logic [31:0]   mem_rdata,
  output logic [31:0]   rf_wdata,
  output logic          rf_we,
  output logic          done
);
  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_DONE} st_t;

  st_t           st;
  logic [1:0]    op_q;
  logic [1:0]    off_q;
  logic [29:0]   wa_q;
  logic [31:0]   reg_q;
  logic [RW-1:0] dst_q;
  logic [31:0]   res_q;
  logic [31:0]   merged;
  logic [4:0]    sh, ish;

  assign sh  = {off_q, 3'b000};
  assign ish = 5'd24 - sh;

  always_comb begin
    case (op_q)
      2'b00:   merged = (reg_q & (32'h00FF_FFFF >> sh)) | (mem_rdata << ish);
      2'b01:   merged = (reg_q & (32'hFFFF_FF00 << ish)) | (mem_rdata >> sh);
      2'b10:   merged = (reg_q >> ish) | (mem_rdata & (32'hFFFF_FF00 << sh));
      default: merged = (reg_q << sh) | (mem_rdata & (32'h00FF_FFFF >> ish));
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      op_q  <= '0;
      off_q <= '0;
      wa_q  <= '0;
      reg_q <= '0;
      dst_q <= '0;
      res_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          op_q  <= op;
          off_q <= addr[1:0];
          wa_q  <= addr[31:2];
          reg_q <= reg_val;
          dst_q <= reg_sel;
          st    <= S_RD;
        end
        S_RD: if (mem_valid) begin
          res_q <= merged;
          st    <= op_q[1] ? S_WR : S_DONE;
        end
        S_WR: if (mem_valid) st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy      = st != S_IDLE;
  assign mem_req   = (st == S_RD) || (st == S_WR);
  assign mem_we    = st == S_WR;
  assign mem_be    = (st == S_WR) ? 4'b1111 : 4'b0000;
  assign mem_addr  = {wa_q, 2'b00};
  assign mem_wdata = res_q;
  assign rf_wdata  = res_q;
  assign done      = st == S_DONE;
  assign rf_we     = (st == S_DONE) && !op_q[1] && (dst_q != '0);
endmodule

// File: rtl/unaligned_merge_chk.sv
module unaligned_merge_chk #(
  parameter int RW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_valid,
  input logic [31:0]   mem_addr,
  input logic [3:0]    mem_be,
  input logic          done,
  input logic          rf_we,
  input logic [RW-1:0] dst_q
);
  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00); // R1
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_valid |=> mem_req && $stable(mem_we) && $stable(mem_addr)); // R7
  AST_WRITE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_be == 4'b1111); // R7
  AST_NO_ZERO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> done && dst_q != '0); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, mem_req})); // R8
endmodule

bind unaligned_merge unaligned_merge_chk #(.RW(RW)) i_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_be(mem_be),
  .done(done), .rf_we(rf_we), .dst_q(dst_q)
);

// File: tb/test_unaligned_merge.sv
module test_unaligned_merge;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0;
  logic [1:0]  op = '0;
  logic [31:0] addr = '0;
  logic [31:0] reg_val = '0;
  logic [4:0]  reg_sel = '0;
  logic        busy, mem_req, mem_we, done, rf_we;
  logic [31:0] mem_addr, mem_wdata, rf_wdata;
  logic [3:0]  mem_be;
  logic        mem_valid = 0;
  logic [31:0] mem_rdata = '0;

  always #4 clk = ~clk;

  unaligned_merge i_unaligned_merge (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .addr(addr),
    .reg_val(reg_val), .reg_sel(reg_sel), .busy(busy), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .mem_valid(mem_valid), .mem_rdata(mem_rdata), .rf_wdata(rf_wdata),
    .rf_we(rf_we), .done(done)
  );

  typedef struct {
    logic        st;
    logic        we;
    logic [31:0] data;
    logic [31:0] waddr;
    string       tag;
  } item_t;

  item_t       sb[$];
  int          checks = 0, failures = 0;
  int          dones = 0, issued = 0;
  int          lat = 0, cnt = 0;
  logic [31:0] memword = '0;
  int          wr_cnt = 0, rd_cnt = 0;
  logic [31:0] wr_addr = '0, wr_data = '0, rd_addr = '0;
  logic [3:0]  wr_be = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [1:0] o, input int k,
                                        input logic [31:0] r, input logic [31:0] m);
    logic [31:0] v;
    for (int j = 0; j < 4; j++) begin
      case (o)
        2'b00: v[j*8 +: 8] = (j >= 3-k) ? m[(j-(3-k))*8 +: 8] : r[j*8 +: 8];
        2'b01: v[j*8 +: 8] = (j <= 3-k) ? m[(j+k)*8 +: 8] : r[j*8 +: 8];
        2'b10: v[j*8 +: 8] = (j <= k) ? r[(j+3-k)*8 +: 8] : m[j*8 +: 8];
        default: v[j*8 +: 8] = (j >= k) ? r[(j-k)*8 +: 8] : m[j*8 +: 8];
      endcase
    end
    return v;
  endfunction

  // memory responder
  always @(negedge clk) begin
    if (mem_valid) begin
      mem_valid <= 0;
      cnt <= 0;
    end else if (mem_req) begin
      if (cnt >= lat) begin
        mem_valid <= 1;
        if (mem_we) begin
          wr_cnt  <= wr_cnt + 1;
          wr_addr <= mem_addr;
          wr_data <= mem_wdata;
          wr_be   <= mem_be;
        end else begin
          rd_cnt    <= rd_cnt + 1;
          rd_addr   <= mem_addr;
          mem_rdata <= memword;
        end
      end else cnt <= cnt + 1;
    end
  end

  // monitor
  int wr_seen = 0;
  always @(negedge clk) begin
    if (rst_n && done) begin
      item_t it;
      dones++;
      if (sb.size() == 0) chk(0, "R8 unexpected done", 32'd1, 32'd0);
      else begin
        it = sb.pop_front();
        chk(rd_addr == it.waddr, {it.tag, " R1 read addr"}, rd_addr, it.waddr);
        if (it.st) begin
          chk(wr_cnt == wr_seen + 1, {it.tag, " R7 one write"}, wr_cnt, wr_seen + 1);
          chk(wr_data == it.data, {it.tag, " data"}, wr_data, it.data);
          chk(wr_addr == it.waddr && wr_be == 4'hF, {it.tag, " R7 write addr/be"}, wr_addr, it.waddr);
          chk(rf_we == 1'b0, {it.tag, " R6 store rf_we"}, rf_we, 0);
        end else begin
          chk(wr_cnt == wr_seen, {it.tag, " R7 load no write"}, wr_cnt, wr_seen);
          chk(rf_we == it.we, {it.tag, " R6 rf_we"}, rf_we, it.we);
          chk(rf_wdata == it.data, {it.tag, " R8 data"}, rf_wdata, it.data);
        end
      end
      wr_seen = wr_cnt;
    end
  end

  task automatic run_op(input logic [1:0] o, input logic [31:0] a, input logic [31:0] r,
                        input logic [4:0] sel, input logic [31:0] m, input string tag,
                        input bit stray);
    item_t it;
    while (busy) @(negedge clk);
    it.st = o[1];
    it.we = !o[1] && sel != 0;
    it.data = model(o, int'(a[1:0]), r, m);
    it.waddr = {a[31:2], 2'b00};
    it.tag = tag;
    sb.push_back(it);
    issued++;
    memword = m;
    op = o; addr = a; reg_val = r; reg_sel = sel; start = 1;
    @(negedge clk);
    start = 0;
    if (stray) begin
      @(negedge clk);
      op = ~o; addr = 32'h0000_0FF3; reg_val = 32'hDEAD_BEEF; reg_sel = 5'd7; start = 1;
      @(negedge clk);
      start = 0;
    end
    while (busy) @(negedge clk);
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req && !done && !rf_we, "R10 reset idle",
        {busy, mem_req, done, rf_we}, 0);
    rst_n = 1;
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      lat = k;
      run_op(2'b00, 32'h1000_0100 | k, 32'hA1A2_A3A4, 5'd3, 32'h1122_3344, "R2 lwl", 0);
      run_op(2'b01, 32'h2000_0200 | k, 32'hB1B2_B3B4, 5'd9, 32'h5566_7788, "R3 lwr", 0);
      run_op(2'b10, 32'h3000_0300 | k, 32'hC1C2_C3C4, 5'd4, 32'h99AA_BBCC, "R4 swl", 0);
      run_op(2'b11, 32'h4000_0400 | k, 32'hD1D2_D3D4, 5'd5, 32'hDDEE_FF00, "R5 swr", 0);
    end
    lat = 1;
    run_op(2'b00, 32'h0000_0041, 32'h0BAD_F00D, 5'd0, 32'hCAFE_BABE, "R6 lwl r0", 0);
    run_op(2'b01, 32'h0000_0052, 32'h0BAD_F00D, 5'd0, 32'hCAFE_BABE, "R6 lwr r0", 0);
    run_op(2'b10, 32'h0000_0063, 32'h0000_0000, 5'd0, 32'hFFFF_FFFF, "R6 swl r0", 0);
    lat = 4;
    run_op(2'b01, 32'h0000_0780, 32'h1234_5678, 5'd2, 32'h8765_4321, "R9 stray start", 1);
    lat = 0;
    run_op(2'b11, 32'h0000_0801, 32'hFEDC_BA98, 5'd6, 32'h0102_0304, "R9 after stray", 0);
    repeat (4) @(negedge clk);
    chk(dones == issued, "R9 done count", dones, issued);
    chk(sb.size() == 0, "R9 scoreboard empty", sb.size(), 0);
    chk(!busy && !mem_req, "R10 idle at end", {busy, mem_req}, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule